// File: doc/BRIEF.md
# Write Leveling Delay Sweep Controller

This block is the controller-side engine for write leveling. During leveling the memory device samples the clock with the incoming data strobe and reports what it saw on a data line. A feedback of 0 says the strobe edge is not yet lined up with the clock. A feedback of 1 says it is. Flight-time differences between the clock and strobe paths are corrected by delaying the strobe, never the clock. The controller therefore starts with a delay code of zero and raises it one tap at a time. For each code it requests one strobe pulse, waits a programmable settling time, then samples the returned feedback bit.

The search looks for a 0-to-1 transition. A 1 seen before any 0 is ignored. The first 1 after a 0 is confirmed by a second pulse at the same code before the code locks, so a single glitch cannot end the search. When the code locks, the block reports whether the locked delay lies inside the acceptable strobe-to-clock skew window of 0.75 to 1.25 clock periods. The clock period is given in delay taps. If the highest allowed tap passes without a lock, the block reports failure.

Top module: `wl_sweep_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it falls, dly_code is 0 and dqs_pulse, done, fail and win_ok are all 0.
- R2: start is accepted only when the block is idle, done or failed. On the edge that accepts it, dly_code becomes 0, done and fail clear, and dqs_pulse is high for the next cycle. A start during a sweep has no effect on dly_code or on the result.
- R3: dqs_pulse is never high in two consecutive cycles. Consecutive pulses are exactly settle_cyc+3 cycles apart: one pulse cycle, settle_cyc+1 wait cycles, one sample cycle. dq_fb is sampled in the last of these cycles.
- R4: A sampled feedback of 0 below max_tap raises dly_code by exactly one before the next pulse. dly_code changes in no other way except the reset to 0 on an accepted start.
- R5: A feedback of 1 sampled before any 0 in the current sweep is ignored, and the code advances as for a 0.
- R6: The first 1 after a 0 repeats the pulse at the same code. A second consecutive 1 at that code sets done, and dly_code then holds that code until the next accepted start.
- R7: If the confirming sample reads 0, it is treated as an ordinary 0 and the code advances.
- R8: If a sample at dly_code == max_tap neither confirms nor locks, fail is set and dly_code holds max_tap until the next start.
- R9: win_ok is 1 only while done is 1 and 3*taps_per_tck <= 4*dly_code <= 5*taps_per_tck, both bounds inclusive.
- R10: done and fail are never 1 together, and dqs_pulse is 0 while either is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new sweep (accepted when not sweeping) |
| dq_fb | input | 1 | Feedback bit returned by the memory device |
| max_tap | input | CODE_W | Highest delay code tried |
| settle_cyc | input | WAIT_W | Extra wait cycles between pulse and sample |
| taps_per_tck | input | CODE_W | Clock period expressed in delay taps |
| dly_code | output | CODE_W | Current or locked strobe delay code |
| dqs_pulse | output | 1 | One-cycle request for a leveling strobe pulse |
| done | output | 1 | Code locked on a confirmed 0-to-1 transition |
| fail | output | 1 | Sweep reached max_tap without a lock |
| win_ok | output | 1 | Locked code lies inside the skew window |

## Verification
On every cycle the assertions check the local rules. Pulses are one cycle wide. The code moves only by single steps or by a restart to zero. A locked code holds. done and fail exclude each other and exclude pulses. win_ok appears only with done. Other behaviour shows only in the bench's scenarios, which drive a feedback model against the delay code: which code is actually locked, that early 1s and a single-sample glitch are ignored, the exact pulse spacing, failure at the tap limit, and the inclusive edges of the skew window.

// File: rtl/wl_sweep_pkg.sv
package wl_sweep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_WAIT,
        ST_SAMPLE,
        ST_DONE,
        ST_FAIL
    } wl_state_e;

    typedef enum logic [1:0] {
        FB_ZERO,     // feedback low: edge not reached
        FB_IGNORE,   // high before any low: discard
        FB_CONFIRM,  // first high after a low: re-pulse same code
        FB_LOCK      // second consecutive high: lock
    } fb_verdict_e;

    // skew window 0.75..1.25 clock periods, as quarters
    localparam int unsigned WIN_LO_Q = 3;
    localparam int unsigned WIN_HI_Q = 5;
    localparam int unsigned WIN_DEN  = 4;

    function automatic logic tap_in_window(input int unsigned code,
                                           input int unsigned tpc);
        int unsigned scaled;
        scaled = code * WIN_DEN;
        return (scaled >= WIN_LO_Q * tpc) && (scaled <= WIN_HI_Q * tpc);
    endfunction

endpackage

// File: rtl/wl_settle_timer.sv
module wl_settle_timer #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              run,
    input  logic [WAIT_W-1:0] settle,
    output logic              expired
);
    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= settle;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R3: the counter only moves down while running
    a_r3_timer_down: assert property (@(posedge clk) disable iff (rst)
        (run && !load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/wl_fb_qualifier.sv
module wl_fb_qualifier
    import wl_sweep_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        sample,
    input  logic        fb,
    output fb_verdict_e verdict
);
    logic seen_zero_q;
    logic one_pending_q;

    always_comb begin
        if (!fb)                verdict = FB_ZERO;
        else if (!seen_zero_q)  verdict = FB_IGNORE;
        else if (one_pending_q) verdict = FB_LOCK;
        else                    verdict = FB_CONFIRM;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            seen_zero_q   <= 1'b0;
            one_pending_q <= 1'b0;
        end else if (sample) begin
            unique case (verdict)
                FB_ZERO: begin
                    seen_zero_q   <= 1'b1;
                    one_pending_q <= 1'b0;
                end
                FB_CONFIRM: one_pending_q <= 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/wl_window_check.sv
module wl_window_check
    import wl_sweep_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              locked,
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] tpc,
    output logic              win_ok
);
    always_comb begin
        win_ok = locked && tap_in_window(int'(unsigned'(code)),
                                         int'(unsigned'(tpc)));
    end
endmodule

// File: rtl/wl_sweep_ctrl.sv
module wl_sweep_ctrl
    import wl_sweep_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dq_fb,
    input  logic [CODE_W-1:0] max_tap,
    input  logic [WAIT_W-1:0] settle_cyc,
    input  logic [CODE_W-1:0] taps_per_tck,
    output logic [CODE_W-1:0] dly_code,
    output logic              dqs_pulse,
    output logic              done,
    output logic              fail,
    output logic              win_ok
);
    wl_state_e         st_q;
    logic [CODE_W-1:0] code_q;
    logic              start_ok;
    logic              settle_over;
    fb_verdict_e       verdict;

    assign start_ok = start &&
                      ((st_q == ST_IDLE) || (st_q == ST_DONE) || (st_q == ST_FAIL));

    wl_settle_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (st_q == ST_PULSE),
        .run     (st_q == ST_WAIT),
        .settle  (settle_cyc),
        .expired (settle_over)
    );

    wl_fb_qualifier u_qual (
        .clk     (clk),
        .rst     (rst),
        .clear   (start_ok),
        .sample  (st_q == ST_SAMPLE),
        .fb      (dq_fb),
        .verdict (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            code_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_DONE, ST_FAIL: begin
                    if (start) begin
                        st_q   <= ST_PULSE;
                        code_q <= '0;
                    end
                end
                ST_PULSE: st_q <= ST_WAIT;
                ST_WAIT: begin
                    if (settle_over) st_q <= ST_SAMPLE;
                end
                ST_SAMPLE: begin
                    unique case (verdict)
                        FB_LOCK:    st_q <= ST_DONE;
                        FB_CONFIRM: st_q <= ST_PULSE;
                        default: begin
                            if (code_q == max_tap) begin
                                st_q <= ST_FAIL;
                            end else begin
                                code_q <= code_q + 1'b1;
                                st_q   <= ST_PULSE;
                            end
                        end
                    endcase
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign dly_code  = code_q;
    assign dqs_pulse = (st_q == ST_PULSE);
    assign done      = (st_q == ST_DONE);
    assign fail      = (st_q == ST_FAIL);

    wl_window_check #(.CODE_W(CODE_W)) u_win (
        .locked (done),
        .code   (code_q),
        .tpc    (taps_per_tck),
        .win_ok (win_ok)
    );

    // R3: strobe requests are single-cycle
    a_r3_pulse_single: assert property (@(posedge clk) disable iff (rst)
        dqs_pulse |=> !dqs_pulse);

    // R4: code moves by one step, or restarts at zero on an accepted start
    a_r4_code_step: assert property (@(posedge clk) disable iff (rst)
        (dly_code != $past(dly_code)) && !$past(start_ok)
            |-> (dly_code == CODE_W'($past(dly_code) + 1'b1)));

    // R6: a locked code holds until a new start
    a_r6_lock_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(dly_code)));

    // R10: outcomes exclude each other and exclude pulses
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && fail) && !(dqs_pulse && (done || fail)));

    // R9: window flag only accompanies a lock
    a_r9_win_needs_lock: assert property (@(posedge clk) disable iff (rst)
        win_ok |-> (done && !fail));

endmodule

// File: tb/tb_wl_sweep_ctrl.sv
module tb_wl_sweep_ctrl;
    localparam int CODE_W = 6;
    localparam int WAIT_W = 4;
    localparam time CLK_PERIOD = 10ns;
    localparam int NVEC = 8;

    // settle, max_tap, tpc, ones_below, edge, glitch, exp_fail, exp_code, exp_win
    localparam int VEC [NVEC][9] = '{
        '{2, 40, 16, 0, 14, 63, 0, 14, 1},  // R4 plain sweep, in window
        '{0, 40, 16, 3, 10, 63, 0, 10, 0},  // R5 early ones ignored, below window
        '{5, 40, 16, 0, 18, 9,  0, 18, 1},  // R7 glitch at 9 rejected
        '{1, 12, 16, 0, 30, 63, 1, 12, 0},  // R8 no edge before limit
        '{0, 8,  16, 63, 63, 63, 1, 8, 0},  // R5/R8 always high, never a zero
        '{1, 20, 16, 0, 20, 63, 0, 20, 1},  // R6 lock at max_tap, upper bound R9
        '{3, 40, 16, 0, 12, 63, 0, 12, 1},  // R9 lower bound inclusive
        '{0, 40, 16, 0, 21, 63, 0, 21, 0}   // R9 just above upper bound
    };

    logic clk = 1'b0;
    logic rst;
    logic start;
    logic dq_fb;
    logic [CODE_W-1:0] max_tap;
    logic [WAIT_W-1:0] settle_cyc;
    logic [CODE_W-1:0] taps_per_tck;
    logic [CODE_W-1:0] dly_code;
    logic dqs_pulse, done, fail, win_ok;

    int total = 0;
    int bad = 0;

    // feedback model parameters
    int m_ones_below = 0;
    int m_edge = 63;
    int m_glitch = 63;
    int pulses_here;
    int last_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    wl_sweep_ctrl #(.CODE_W(CODE_W), .WAIT_W(WAIT_W)) dut (
        .clk(clk), .rst(rst), .start(start), .dq_fb(dq_fb),
        .max_tap(max_tap), .settle_cyc(settle_cyc), .taps_per_tck(taps_per_tck),
        .dly_code(dly_code), .dqs_pulse(dqs_pulse), .done(done),
        .fail(fail), .win_ok(win_ok)
    );

    always @(posedge clk) begin
        if (rst || start) begin
            pulses_here <= 0;
            last_code   <= 255;
        end else if (dqs_pulse) begin
            pulses_here <= (int'(dly_code) == last_code) ? pulses_here + 1 : 1;
            last_code   <= int'(dly_code);
        end
    end

    always_comb begin
        dq_fb = (int'(dly_code) < m_ones_below) || (int'(dly_code) >= m_edge) ||
                ((int'(dly_code) == m_glitch) && (pulses_here == 1));
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(input string req);
        int n = 0;
        while (!(done || fail) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 5000) chk({req, " timeout"}, 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        start = 1'b0;
        max_tap = 6'd40;
        settle_cyc = 4'd2;
        taps_per_tck = 6'd16;
        repeat (3) @(negedge clk);
        chk("R1 code in reset", int'(dly_code), 0);
        chk("R1 pulse in reset", int'(dqs_pulse), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done/fail after reset", int'(done) + int'(fail), 0);
        chk("R1 win_ok after reset", int'(win_ok), 0);

        for (int v = 0; v < NVEC; v++) begin
            settle_cyc   = WAIT_W'(VEC[v][0]);
            max_tap      = CODE_W'(VEC[v][1]);
            taps_per_tck = CODE_W'(VEC[v][2]);
            m_ones_below = VEC[v][3];
            m_edge       = VEC[v][4];
            m_glitch     = VEC[v][5];
            pulse_start();
            wait_end("R6 vector");
            chk($sformatf("R8 fail flag vec%0d", v), int'(fail), VEC[v][6]);
            chk($sformatf("R6 done flag vec%0d", v), int'(done), 1 - VEC[v][6]);
            chk($sformatf("R4 final code vec%0d", v), int'(dly_code), VEC[v][7]);
            chk($sformatf("R9 window vec%0d", v), int'(win_ok), VEC[v][8]);
            repeat (3) @(negedge clk);
            chk($sformatf("R6 code holds vec%0d", v), int'(dly_code), VEC[v][7]);
        end

        // R3 pulse spacing: settle 4 -> 7 cycles
        settle_cyc = 4'd4; max_tap = 6'd40; m_ones_below = 0; m_edge = 30; m_glitch = 63;
        pulse_start();
        chk("R2 pulse right after start", int'(dqs_pulse), 1);
        chk("R2 code cleared on start", int'(dly_code), 0);
        chk("R2 done cleared on start", int'(done), 0);
        begin
            int gap = 0;
            @(negedge clk);
            chk("R3 pulse one cycle", int'(dqs_pulse), 0);
            gap = 1;
            while (!dqs_pulse && gap < 100) begin
                @(negedge clk);
                gap++;
            end
            chk("R3 pulse spacing", gap, 7);
        end
        wait_end("R3");
        chk("R4 code after spacing run", int'(dly_code), 30);

        // R2 start during sweep is ignored
        settle_cyc = 4'd2; m_edge = 14;
        pulse_start();
        begin
            int n = 0;
            while (int'(dly_code) != 5 && n < 1000) begin
                @(negedge clk);
                n++;
            end
        end
        pulse_start();
        chk("R2 mid-sweep start ignored", int'(dly_code >= 6'd5), 1);
        wait_end("R2");
        chk("R2 result unaffected", int'(dly_code), 14);
        chk("R2 done after ignored start", int'(done), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule